// File: doc/BRIEF.md
# Register-Mapped Serial Port with Selectable Framing

This block is an asynchronous serial transmitter and receiver that sits behind a plain 32-bit register bus. Software queues characters by writing a transmit data register, which feeds a transmit FIFO. It collects received characters by reading a receive data register, which pops a receive FIFO. A control register selects the character length, parity, stop bits, the two enables, per-direction resets, interrupt enables and an error-clear bit. A status register reports the latched error flags and the FIFO and shifter state.

Bit timing comes from an external rate generator. That generator supplies `baud_tick`, which runs at sixteen times the bit rate. Each transmitted bit lasts sixteen ticks. The receiver resynchronises the line, confirms a start bit at its half-bit point, and then samples every later bit at mid-period.

The receiver keeps per-character parity and framing flags next to each character in its FIFO, so software can recognise a line break as an all-zero character that carries a framing error. Sticky error flags in the status register stay set until software raises and then lowers the clear bit.

Top module: `regbus_uart`

## Requirements
- R1: After reset, status reads 0x0050_0000 (receive-empty bit 20 and transmit-empty bit 22 set, all other bits zero), `txd` is 1, and both interrupt outputs are 0.
- R2: A transmitted frame has the following shape, with every bit lasting 16 `baud_tick` pulses:
  - a low start bit;
  - data bits LSB first, their number set by control bits 21:20 (00=8, 01=7, 10=6, 11=5);
  - a parity bit when control bit 19 is 1, odd when control bit 18 is 1 and even when it is 0;
  - one high stop bit, or two when control bits 17:16 are 01.
- R3: Characters leave the transmit FIFO only while control bit 12 is 1. Status bit 22 is 1 exactly when the transmit FIFO is empty, and status bit 25 is 1 while a frame is being shifted out.
- R4: A write to offset 0x00 while the transmit FIFO is full (status bit 21) is dropped and sets status bit 18.
- R5: A frame received on `rxd` while control bit 13 is 1 is stored in the receive FIFO. A read of offset 0x04 pops one entry and returns the character in bits 7:0, with the unused upper data bits zero for short lengths. Status bit 20 is 1 while the receive FIFO is empty.
- R6: A received parity mismatch sets the sticky status bit 16, and the receive data read shows bit 8 set for that character.
- R7: A stop bit sampled low sets the sticky status bit 17, and the receive data read shows bit 9 set for that character. A break (line held low) yields a single all-zero entry with bit 9 set. No further frame starts until the line returns high.
- R8: Status bits 16, 17 and 18 stay set until control bit 24 is written 1. They read 0 while bit 24 is held at 1, and they can set again once it is written back to 0.
- R9: While control bit 13 is 0, activity on `rxd` adds nothing to the receive FIFO.
- R10: While control bit 22 is 1, the transmit FIFO is emptied and the transmitter is idle with `txd` high. Control bit 23 does the same for the receive side.
- R11: `irq_rx` is 1 when control bit 27 is 1 and the receive FIFO count is at least threshold bits 7:0. `irq_tx` is 1 when control bit 28 is 1 and the transmit FIFO count is below threshold bits 15:8. The threshold register is at offset 0x10.
- R12: Reads return the written values of the control register (offset 0x08, defined bits only: mask 0x19FF_B000), the threshold register (offset 0x10, bits 15:0) and the rate configuration register (offset 0x14, bits 23:0). Control bit 15 is only stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive FIFO at 0x04) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| baud_tick | input | 1 | One-cycle pulse at sixteen times the bit rate |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_rx | output | 1 | Receive level interrupt |
| irq_tx | output | 1 | Transmit level interrupt |

## Verification
The bench first sends characters in every length, parity and stop-bit mode through a loopback and samples `txd` at mid-bit. A design that counted data bits from the wrong field or inverted the parity sense would then show a wrong serial pattern, or the character would come back unmasked. The next tests drive a wrong parity bit and a held-low break from the bench. A receiver that dropped the per-entry flags, cleared sticky flags on read, or restarted on a still-low line would leave a second phantom entry or a lost break indication. Overfilling the transmit FIFO exposes a design that wraps its write pointer instead of dropping the write. A test that disables the receiver while frames arrive exposes a design that does not gate reception on its enable. The interrupt thresholds are checked exactly at their boundary counts, where an off-by-one comparison would show.

// File: rtl/uartp_pkg.sv
package uartp_pkg;

   localparam logic [7:0] OFF_TXD  = 8'h00;
   localparam logic [7:0] OFF_RXD  = 8'h04;
   localparam logic [7:0] OFF_CTL  = 8'h08;
   localparam logic [7:0] OFF_STA  = 8'h0C;
   localparam logic [7:0] OFF_THR  = 8'h10;
   localparam logic [7:0] OFF_RATE = 8'h14;

   localparam int CB_TXEN  = 12;
   localparam int CB_RXEN  = 13;
   localparam int CB_STOP  = 16;
   localparam int CB_PODD  = 18;
   localparam int CB_PEN   = 19;
   localparam int CB_LEN   = 20;
   localparam int CB_TXRST = 22;
   localparam int CB_RXRST = 23;
   localparam int CB_CLR   = 24;
   localparam int CB_RXIE  = 27;
   localparam int CB_TXIE  = 28;

   localparam logic [31:0] CTL_MASK = 32'h19FF_B000;

   localparam int SB_PERR = 16;
   localparam int SB_FERR = 17;
   localparam int SB_OVF  = 18;
   localparam int SB_RXE  = 20;
   localparam int SB_TXF  = 21;
   localparam int SB_TXE  = 22;
   localparam int SB_BUSY = 25;

   typedef struct packed {
      logic [1:0] len;     // 0:8 1:7 2:6 3:5 data bits
      logic       par_en;
      logic       par_odd;
      logic       stop2;
   } frame_cfg_t;

   function automatic logic [3:0] data_bits(input logic [1:0] len);
      return 4'd8 - {2'b00, len};
   endfunction

   function automatic logic [7:0] data_mask(input logic [1:0] len);
      return 8'hFF >> len;
   endfunction

endpackage

// File: rtl/uartp_fifo.sv
module uartp_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic [$clog2(DEPTH):0] count,
   output logic         full,
   output logic         empty
);
   localparam int AW = $clog2(DEPTH);

   generate
      if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
         $error("uartp_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign full    = (count == (AW+1)'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0; rp <= '0; count <= '0;
      end else if (flush) begin
         wp <= '0; rp <= '0; count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
      end
   end

   a_r4_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> (count == $past(count)));
   a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);
   a_r4_never_overfill: assert property (@(posedge clk) disable iff (!rst_n)
      count <= (AW+1)'(DEPTH));
endmodule

// File: rtl/uartp_tx.sv
module uartp_tx
   import uartp_pkg::*;
#(
   parameter int OSR = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       srst,
   input  logic       en,
   input  frame_cfg_t cfg,
   input  logic       baud_tick,
   input  logic       fifo_empty,
   input  logic [7:0] fifo_data,
   output logic       pop,
   output logic       busy,
   output logic       txd
);
   localparam int CW = $clog2(OSR);

   typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tx_st_t;

   tx_st_t        st;
   frame_cfg_t    cfg_q;
   logic [7:0]    sh;
   logic          par_q, stop_n;
   logic [CW-1:0] cnt;
   logic [2:0]    bidx;
   logic          last;
   logic [7:0]    masked;

   assign masked = fifo_data & data_mask(cfg.len);
   assign pop    = (st == T_IDLE) && en && !fifo_empty && !srst;
   assign busy   = (st != T_IDLE);
   assign last   = baud_tick && (cnt == CW'(OSR - 1));

   always_comb begin
      case (st)
         T_START: txd = 1'b0;
         T_DATA:  txd = sh[0];
         T_PAR:   txd = par_q;
         default: txd = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= T_IDLE; cfg_q <= '0; sh <= '0; par_q <= 1'b0;
         stop_n <= 1'b0; cnt <= '0; bidx <= '0;
      end else if (srst) begin
         st <= T_IDLE; cnt <= '0;
      end else begin
         if (baud_tick && st != T_IDLE) cnt <= last ? '0 : cnt + 1'b1;
         case (st)
            T_IDLE: if (pop) begin
               st <= T_START; cfg_q <= cfg; sh <= masked;
               par_q <= (^masked) ^ cfg.par_odd;
               cnt <= '0; bidx <= '0; stop_n <= 1'b0;
            end
            T_START: if (last) st <= T_DATA;
            T_DATA: if (last) begin
               sh   <= sh >> 1;
               bidx <= bidx + 1'b1;
               if ({1'b0, bidx} == data_bits(cfg_q.len) - 4'd1)
                  st <= cfg_q.par_en ? T_PAR : T_STOP;
            end
            T_PAR: if (last) st <= T_STOP;
            T_STOP: if (last) begin
               if (cfg_q.stop2 && !stop_n) stop_n <= 1'b1;
               else st <= T_IDLE;
            end
            default: st <= T_IDLE;
         endcase
      end
   end

   a_r10_tx_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (!busy && txd));
   a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !en) |=> !busy);
   a_r2_start_is_low: assert property (@(posedge clk) disable iff (!rst_n)
      (pop) |=> !txd);
endmodule

// File: rtl/uartp_rx.sv
module uartp_rx
   import uartp_pkg::*;
#(
   parameter int OSR  = 16,
   parameter int SYNC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       srst,
   input  logic       en,
   input  frame_cfg_t cfg,
   input  logic       baud_tick,
   input  logic       rxd,
   output logic       push,
   output logic [7:0] pdata,
   output logic       perr,
   output logic       ferr
);
   localparam int CW   = $clog2(OSR);
   localparam int HALF = OSR / 2 - 1;

   typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_HOLD} rx_st_t;

   logic [SYNC-1:0] sy;
   logic            rx_s;

   generate
      for (genvar i = 0; i < SYNC; i++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sy[i] <= 1'b1;
            else if (i == 0) sy[i] <= rxd;
            else sy[i] <= sy[(i == 0) ? 0 : i - 1];
         end
      end
   endgenerate
   assign rx_s = sy[SYNC-1];

   rx_st_t        st;
   frame_cfg_t    cfg_q;
   logic [7:0]    sh, aligned;
   logic          par_bit;
   logic [CW-1:0] cnt;
   logic [2:0]    bidx;
   logic          last;

   assign last    = baud_tick && (cnt == CW'(OSR - 1));
   assign aligned = sh >> cfg_q.len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= R_IDLE; cfg_q <= '0; sh <= '0; par_bit <= 1'b0; cnt <= '0;
         bidx <= '0; push <= 1'b0; pdata <= '0; perr <= 1'b0; ferr <= 1'b0;
      end else if (srst || !en) begin
         st <= R_IDLE; push <= 1'b0; cnt <= '0;
      end else begin
         push <= 1'b0;
         case (st)
            R_IDLE: if (!rx_s) begin
               st <= R_START; cnt <= '0; cfg_q <= cfg;
            end
            R_START: if (baud_tick) begin
               if (cnt == CW'(HALF)) begin
                  cnt <= '0; bidx <= '0;
                  st  <= rx_s ? R_IDLE : R_DATA;
               end else cnt <= cnt + 1'b1;
            end
            R_DATA: if (baud_tick) begin
               cnt <= last ? '0 : cnt + 1'b1;
               if (last) begin
                  sh   <= {rx_s, sh[7:1]};
                  bidx <= bidx + 1'b1;
                  if ({1'b0, bidx} == data_bits(cfg_q.len) - 4'd1)
                     st <= cfg_q.par_en ? R_PAR : R_STOP;
               end
            end
            R_PAR: if (baud_tick) begin
               cnt <= last ? '0 : cnt + 1'b1;
               if (last) begin par_bit <= rx_s; st <= R_STOP; end
            end
            R_STOP: if (baud_tick) begin
               cnt <= last ? '0 : cnt + 1'b1;
               if (last) begin
                  push  <= 1'b1;
                  pdata <= aligned;
                  perr  <= cfg_q.par_en && (par_bit != ((^aligned) ^ cfg_q.par_odd));
                  ferr  <= !rx_s;
                  st    <= rx_s ? R_IDLE : R_HOLD;
               end
            end
            R_HOLD: if (rx_s) st <= R_IDLE;
            default: st <= R_IDLE;
         endcase
      end
   end

   a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !push);
   a_r7_no_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
      (push && ferr && en && !srst) |=> (st == R_HOLD || !en || srst));
   a_r5_single_push: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> !push);
endmodule

// File: rtl/regbus_uart.sv
module regbus_uart
   import uartp_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int OSR   = 16,
   parameter int SYNC  = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [7:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic        baud_tick,
   input  logic        rxd,
   output logic        txd,
   output logic        irq_rx,
   output logic        irq_tx
);
   localparam int CNTW = $clog2(DEPTH) + 1;
   localparam int RXW  = 10;

   generate
      if (DEPTH != 64 && DEPTH != 128) begin : g_bad_depth
         $error("regbus_uart: DEPTH must be 64 or 128");
      end
      if (OSR < 4 || (OSR & (OSR - 1)) != 0) begin : g_bad_osr
         $error("regbus_uart: OSR must be a power of two of at least 4");
      end
      if (SYNC < 2) begin : g_bad_sync
         $error("regbus_uart: SYNC must be at least 2");
      end
   endgenerate

   logic [31:0] ctl;
   logic [15:0] thr;
   logic [23:0] rate;
   logic        perr_f, ferr_f, ovf_f;
   frame_cfg_t  cfg;

   assign cfg.len     = ctl[CB_LEN+1:CB_LEN];
   assign cfg.par_en  = ctl[CB_PEN];
   assign cfg.par_odd = ctl[CB_PODD];
   assign cfg.stop2   = (ctl[CB_STOP+1:CB_STOP] == 2'b01);

   logic wr_ctl, wr_thr, wr_rate, wr_txd, rd_rxd;
   assign wr_ctl  = bus_wr && bus_addr == OFF_CTL;
   assign wr_thr  = bus_wr && bus_addr == OFF_THR;
   assign wr_rate = bus_wr && bus_addr == OFF_RATE;
   assign wr_txd  = bus_wr && bus_addr == OFF_TXD;
   assign rd_rxd  = bus_rd && bus_addr == OFF_RXD;

   // transmit path
   logic [7:0]      txf_dout;
   logic [CNTW-1:0] txf_cnt;
   logic            txf_full, txf_empty, tx_pop, tx_busy;

   uartp_fifo #(.W(8), .DEPTH(DEPTH)) u_txf (
      .clk(clk), .rst_n(rst_n), .flush(ctl[CB_TXRST]),
      .push(wr_txd), .din(bus_wdata[7:0]), .pop(tx_pop),
      .dout(txf_dout), .count(txf_cnt), .full(txf_full), .empty(txf_empty));

   uartp_tx #(.OSR(OSR)) u_tx (
      .clk(clk), .rst_n(rst_n), .srst(ctl[CB_TXRST]), .en(ctl[CB_TXEN]),
      .cfg(cfg), .baud_tick(baud_tick), .fifo_empty(txf_empty),
      .fifo_data(txf_dout), .pop(tx_pop), .busy(tx_busy), .txd(txd));

   // receive path
   logic [7:0]      rx_data;
   logic            rx_push, rx_perr, rx_ferr;
   logic [RXW-1:0]  rxf_dout;
   logic [CNTW-1:0] rxf_cnt;
   logic            rxf_full, rxf_empty;

   uartp_rx #(.OSR(OSR), .SYNC(SYNC)) u_rx (
      .clk(clk), .rst_n(rst_n), .srst(ctl[CB_RXRST]), .en(ctl[CB_RXEN]),
      .cfg(cfg), .baud_tick(baud_tick), .rxd(rxd), .push(rx_push),
      .pdata(rx_data), .perr(rx_perr), .ferr(rx_ferr));

   uartp_fifo #(.W(RXW), .DEPTH(DEPTH)) u_rxf (
      .clk(clk), .rst_n(rst_n), .flush(ctl[CB_RXRST]),
      .push(rx_push), .din({rx_ferr, rx_perr, rx_data}), .pop(rd_rxd),
      .dout(rxf_dout), .count(rxf_cnt), .full(rxf_full), .empty(rxf_empty));

   // registers and sticky flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0; thr <= '0; rate <= '0;
         perr_f <= 1'b0; ferr_f <= 1'b0; ovf_f <= 1'b0;
      end else begin
         if (wr_ctl)  ctl  <= bus_wdata & CTL_MASK;
         if (wr_thr)  thr  <= bus_wdata[15:0];
         if (wr_rate) rate <= bus_wdata[23:0];
         if (ctl[CB_CLR]) begin
            perr_f <= 1'b0; ferr_f <= 1'b0; ovf_f <= 1'b0;
         end else begin
            if (rx_push && rx_perr)  perr_f <= 1'b1;
            if (rx_push && rx_ferr)  ferr_f <= 1'b1;
            if (wr_txd && txf_full)  ovf_f  <= 1'b1;
         end
      end
   end

   logic [31:0] sta;
   always_comb begin
      sta          = '0;
      sta[SB_PERR] = perr_f;
      sta[SB_FERR] = ferr_f;
      sta[SB_OVF]  = ovf_f;
      sta[SB_RXE]  = rxf_empty;
      sta[SB_TXF]  = txf_full;
      sta[SB_TXE]  = txf_empty;
      sta[SB_BUSY] = tx_busy;
   end

   always_comb begin
      case (bus_addr)
         OFF_RXD:  bus_rdata = rxf_empty ? 32'd0 : {22'd0, rxf_dout};
         OFF_CTL:  bus_rdata = ctl;
         OFF_STA:  bus_rdata = sta;
         OFF_THR:  bus_rdata = {16'd0, thr};
         OFF_RATE: bus_rdata = {8'd0, rate};
         default:  bus_rdata = 32'd0;
      endcase
   end

   assign irq_rx = ctl[CB_RXIE] && ({1'b0, rxf_cnt} >= (CNTW+1)'(thr[7:0]));
   assign irq_tx = ctl[CB_TXIE] && ({1'b0, txf_cnt} <  (CNTW+1)'(thr[15:8]));

   a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ctl[CB_CLR] |=> (!perr_f && !ferr_f && !ovf_f));
   a_r4_overflow_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_txd && txf_full && !ctl[CB_CLR]) |=> ovf_f);
   a_r11_rx_irq_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (rxf_empty && thr[7:0] != 8'd0) |-> !irq_rx);
   a_r8_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (perr_f && !ctl[CB_CLR]) |=> perr_f);
endmodule

// File: tb/regbus_uart_test.sv
module regbus_uart_test;
   localparam int DEPTH = 64;
   localparam int OSR   = 16;

   // {len[1:0], par_en, par_odd, stop2, data[7:0]}
   localparam logic [12:0] VEC [6] = '{
      {2'b00, 1'b0, 1'b0, 1'b0, 8'h5A},
      {2'b01, 1'b1, 1'b0, 1'b1, 8'hC3},
      {2'b10, 1'b1, 1'b1, 1'b0, 8'hFF},
      {2'b11, 1'b0, 1'b0, 1'b1, 8'h8E},
      {2'b00, 1'b1, 1'b1, 1'b0, 8'h00},
      {2'b00, 1'b1, 1'b0, 1'b0, 8'h81}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        baud_tick = 1'b1;
   logic        rxd, txd, irq_rx, irq_tx;
   logic        loop_on = 1'b1;
   logic        rx_drv = 1'b1;
   int          total = 0, bad = 0;

   assign rxd = loop_on ? txd : rx_drv;

   always #5 clk = ~clk;

   regbus_uart #(.DEPTH(DEPTH), .OSR(OSR), .SYNC(2)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .baud_tick(baud_tick), .rxd(rxd), .txd(txd),
      .irq_rx(irq_rx), .irq_tx(irq_tx));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wait_rx(output logic got);
      logic [31:0] s;
      got = 1'b0;
      for (int i = 0; i < 400 && !got; i++) begin
         rd(8'h0C, s);
         got = !s[20];
      end
   endtask

   task automatic drive_line(input logic [15:0] bits, input int n);
      for (int i = 0; i < n; i++) begin
         rx_drv = bits[i];
         repeat (OSR) @(negedge clk);
      end
      rx_drv = 1'b1;
   endtask

   // capture one frame from txd at mid-bit and compare against the R2 shape
   task automatic grab_frame(input logic [1:0] len, input logic pen, input logic podd,
                             input logic st2, input logic [7:0] d);
      logic [15:0] exp_b, act_b;
      int          n, k;
      logic [7:0]  dm;
      exp_b = '0; act_b = '0;
      n  = 8 - int'(len);
      dm = d & (8'hFF >> len);
      k  = 0;
      exp_b[k++] = 1'b0;
      for (int i = 0; i < n; i++) exp_b[k++] = dm[i];
      if (pen) exp_b[k++] = (^dm) ^ podd;
      exp_b[k++] = 1'b1;
      if (st2) exp_b[k++] = 1'b1;
      for (int t = 0; t < 2000 && txd; t++) @(negedge clk);
      repeat (OSR / 2) @(negedge clk);
      for (int i = 0; i < k; i++) begin
         act_b[i] = txd;
         if (i != k - 1) repeat (OSR) @(negedge clk);
      end
      chk("R2 tx frame bits", {16'd0, act_b}, {16'd0, exp_b});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic        got;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(8'h0C, v);
      chk("R1 status after reset", v, 32'h0050_0000);
      chk("R1 txd idle high", {31'd0, txd}, 32'd1);
      chk("R1 irqs low", {30'd0, irq_rx, irq_tx}, 32'd0);

      // R12 readback
      wr(8'h08, 32'hFFFF_FFFF);
      rd(8'h08, v);
      chk("R12 control readback", v, 32'h19FF_B000);
      wr(8'h08, 32'h0000_8000);
      rd(8'h08, v);
      chk("R12 control bit15 stored", v, 32'h0000_8000);
      wr(8'h08, 32'h0100_0000);
      wr(8'h08, 32'h0);
      wr(8'h10, 32'hABCD_1234);
      rd(8'h10, v);
      chk("R12 threshold readback", v, 32'h0000_1234);
      wr(8'h14, 32'hFF12_3456);
      rd(8'h14, v);
      chk("R12 rate readback", v, 32'h0012_3456);
      wr(8'h10, 32'h0);

      // R2 / R5 table of loopback frames
      foreach (VEC[k]) begin
         logic [1:0] len; logic pen, podd, st2; logic [7:0] d;
         {len, pen, podd, st2, d} = VEC[k];
         wr(8'h08, (32'd1 << 12) | (32'd1 << 13) | (32'(len) << 20) |
                   (32'(pen) << 19) | (32'(podd) << 18) | (32'(st2) << 16));
         wr(8'h00, {24'd0, d});
         grab_frame(len, pen, podd, st2, d);
         wait_rx(got);
         chk("R5 rx char arrived", {31'd0, got}, 32'd1);
         rd(8'h04, v);
         chk("R5 rx data masked, no error bits", v, {24'd0, d & (8'hFF >> len)});
      end
      rd(8'h0C, v);
      chk("R5 rx empty after pops, no sticky errors", v, 32'h0050_0000);

      // R3 / R9: tx disabled holds the character; rx disabled ignores line
      wr(8'h08, 32'h0);
      wr(8'h00, 32'h33);
      repeat (64) @(negedge clk);
      chk("R3 txd stays high while disabled", {31'd0, txd}, 32'd1);
      rd(8'h0C, v);
      chk("R3 not empty, not busy", {30'd0, v[25], v[22]}, 32'd0);
      wr(8'h08, 32'h0000_1000);
      rd(8'h0C, v);
      chk("R3 busy while shifting", {30'd0, v[25], v[22]}, 32'd3);
      repeat (200) @(negedge clk);
      rd(8'h0C, v);
      chk("R3 done: empty and idle", {30'd0, v[25], v[22]}, 32'd1);
      chk("R9 nothing received while rx disabled", {31'd0, v[20]}, 32'd1);

      // R11 tx level, R4 overflow, R10 tx reset, R8 clear
      wr(8'h10, 32'h0000_0302);
      wr(8'h08, 32'h1000_0000);
      @(negedge clk);
      chk("R11 irq_tx at count 0 below level 3", {31'd0, irq_tx}, 32'd1);
      for (int i = 0; i < 3; i++) wr(8'h00, 32'(i));
      chk("R11 irq_tx low at count 3", {31'd0, irq_tx}, 32'd0);
      for (int i = 3; i < DEPTH + 1; i++) wr(8'h00, 32'(i));
      rd(8'h0C, v);
      chk("R4 full and overflow flag", {29'd0, v[22], v[21], v[18]}, 32'd3);
      wr(8'h08, 32'h1040_0000);
      rd(8'h0C, v);
      chk("R10 tx reset empties fifo", {29'd0, v[22], v[21], v[25]}, 32'd4);
      chk("R8 overflow still latched after tx reset", {31'd0, v[18]}, 32'd1);
      wr(8'h08, 32'h0100_0000);
      rd(8'h0C, v);
      chk("R8 clear bit drops flags", {29'd0, v[18:16]}, 32'd0);
      wr(8'h08, 32'h0);

      // R11 rx level with bench-driven frames
      loop_on = 1'b0;
      wr(8'h08, 32'h0800_2000);
      drive_line({6'h3F, 1'b1, 8'h11, 1'b0}, 10);
      repeat (8) @(negedge clk);
      chk("R11 irq_rx low at count 1 below 2", {31'd0, irq_rx}, 32'd0);
      drive_line({6'h3F, 1'b1, 8'h22, 1'b0}, 10);
      repeat (8) @(negedge clk);
      chk("R11 irq_rx high at count 2", {31'd0, irq_rx}, 32'd1);
      rd(8'h04, v);
      chk("R5 first bench frame", v, 32'h11);
      rd(8'h04, v);
      chk("R5 second bench frame", v, 32'h22);

      // R6 parity error, 8 data even parity, wrong parity bit
      wr(8'h08, 32'h0008_2000);
      drive_line({5'h1F, 1'b1, 1'b1, 8'hA5, 1'b0}, 11);
      repeat (8) @(negedge clk);
      rd(8'h04, v);
      chk("R6 per-entry parity bit", v, 32'h0000_01A5);
      rd(8'h0C, v);
      chk("R6 sticky parity flag", {30'd0, v[17:16]}, 32'd1);
      chk("R8 flag kept after the pop", {31'd0, v[16]}, 32'd1);

      // R7 break
      wr(8'h08, 32'h0000_2000);
      drive_line({6'd0, 1'b0, 8'h00, 1'b0}, 10);
      rx_drv = 1'b0;
      repeat (40) @(negedge clk);
      rx_drv = 1'b1;
      repeat (40) @(negedge clk);
      rd(8'h04, v);
      chk("R7 break entry zero with frame bit", v, 32'h0000_0200);
      rd(8'h0C, v);
      chk("R7 single entry and sticky frame flag", {30'd0, v[20], v[17]}, 32'd3);
      wr(8'h08, 32'h0100_2000);
      rd(8'h0C, v);
      chk("R8 flags zero while clear held", {29'd0, v[18:16]}, 32'd0);
      wr(8'h08, 32'h0000_2000);

      // R10 rx reset flushes a stored character
      drive_line({6'h3F, 1'b1, 8'h5C, 1'b0}, 10);
      repeat (8) @(negedge clk);
      wr(8'h08, 32'h0080_2000);
      rd(8'h0C, v);
      chk("R10 rx reset empties fifo", {31'd0, v[20]}, 32'd1);

      // R9 rx disabled
      wr(8'h08, 32'h0);
      drive_line({6'h3F, 1'b1, 8'h77, 1'b0}, 10);
      repeat (8) @(negedge clk);
      rd(8'h0C, v);
      chk("R9 disabled receiver stores nothing", {31'd0, v[20]}, 32'd1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule